// File: doc/BRIEF.md
# Conditional Branch Resolver

This block takes one 32-bit instruction word at a time, together with the address it was fetched from and the current four-bit condition flags. It decides whether the word is a branch and whether that branch is taken. It then returns the address to fetch next, and whether the return address should be saved in the link register. A fetch unit feeds it one word per transfer. A redirect unit and the register-file write port use its results.

The condition nibble is tested against the flags no matter which instruction set them; only the current flag values matter. A taken branch adds its word offset to a base that runs two words ahead of the instruction address. The sum wraps at 32 bits. Any other outcome falls through to the next sequential word.

Both edges follow a valid/ready handshake. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears one cycle later with `out_valid` raised, and it leaves on an edge where `out_valid` and `out_ready` are both high. While the downstream side holds `out_ready` low, the result stays frozen and `in_ready` drops. `in_ready` is high whenever the output register is empty or is being drained in the same cycle.

Top module: `br_resolver`

## Requirements
- R1: `in_flags` is ordered {N,Z,C,V} from bit 3 down to bit 0. The condition nibble in bits 31:28 passes as follows:
  - 0: Z
  - 1: !Z
  - 2: C
  - 3: !C
  - 4: N
  - 5: !N
  - 6: V
  - 7: !V
  - 8: C&!Z
  - 9: !C|Z
  - A: N==V
  - B: N!=V
  - C: !Z&(N==V)
  - D: Z|(N!=V)
  - E: always
- R2: Condition nibble 0xF never passes, so the result is never taken.
- R3: A word is a branch only when bits 27:25 equal 3'b101. Any other word gives `out_taken`=0, `out_link_we`=0 and `out_next_pc` = address+4.
- R4: A taken branch gives `out_next_pc` = address + 8 + 4 × (bits 23:0 sign-extended). For example, 0x1AFFFFF9 at 0x1000 with Z clear goes to 0x0FEC.
- R5: A branch whose condition fails gives `out_next_pc` = address + 4.
- R6: `out_link_we` is 1 only when bit 24 is 1 and the branch is taken. `out_link_pc` always equals address + 4.
- R7: A result appears with `out_valid` on the cycle after its word is accepted.
- R8: While `out_valid` is 1 and `out_ready` is 0, all outputs hold their values and `in_ready` is 0. Results leave in the order their words were accepted.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.
- R10: All address sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_insn | input | 32 | Instruction word |
| in_pc | input | 32 | Address of the instruction word |
| in_flags | input | 4 | Condition flags {N,Z,C,V} |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Downstream accepts the result |
| out_taken | output | 1 | Branch is taken |
| out_next_pc | output | 32 | Next fetch address |
| out_link_we | output | 1 | Request to write `out_link_pc` to register 14 |
| out_link_pc | output | 32 | Return address |

## Verification
The assertions assume the upstream side keeps its word and flags steady only on the edge where the transfer happens. They also assume `out_ready` may change on any cycle, and that reset is released away from a clock edge. The stimulus drives inputs one time unit after each rising edge. It holds `in_valid` until `in_ready` has been seen high at the edge. During the main sweep it randomly withholds `out_ready` so that stalls and back-to-back transfers both occur. Address and offset values are chosen to reach both ends of the 32-bit range, so the wrap assertions and scoreboard checks see the carry cases.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam int ADDR_W   = 32;
  localparam int INSN_W   = 32;
  localparam int OFFS_W   = 24;
  localparam int FLAG_W   = 4;
  localparam int COND_W   = 4;
  // flag positions inside the flag vector
  localparam int FLG_N    = 3;
  localparam int FLG_Z    = 2;
  localparam int FLG_C    = 1;
  localparam int FLG_V    = 0;
  // branch class pattern in the major opcode bits
  localparam logic [2:0] BR_CLASS = 3'b101;

  typedef enum logic [COND_W-1:0] {
    CC_EQ = 4'h0, CC_NE = 4'h1, CC_HS = 4'h2, CC_LO = 4'h3,
    CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
    CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
    CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
  } cond_e;

  typedef struct packed {
    logic              taken;
    logic [ADDR_W-1:0] next_pc;
    logic              link_we;
    logic [ADDR_W-1:0] link_pc;
  } br_result_t;

  localparam int RES_W = $bits(br_result_t);
endpackage

// File: rtl/br_decode.sv
module br_decode
  import br_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output cond_e             cond,
  output logic              is_branch,
  output logic              is_link,
  output logic [OFFS_W-1:0] offset
);
  localparam int COND_LSB = INSN_W - COND_W;
  localparam int CLS_LSB  = COND_LSB - 3;
  localparam int LINK_BIT = CLS_LSB - 1;

  always_comb begin
    cond      = cond_e'(insn[INSN_W-1:COND_LSB]);
    is_branch = (insn[COND_LSB-1:CLS_LSB] == BR_CLASS);
    is_link   = insn[LINK_BIT];
    offset    = insn[OFFS_W-1:0];
  end
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
(
  input  cond_e             cond,
  input  logic [FLAG_W-1:0] flags,
  output logic              pass
);
  logic f_n, f_z, f_c, f_v, sgn_ok;

  always_comb begin
    f_n    = flags[FLG_N];
    f_z    = flags[FLG_Z];
    f_c    = flags[FLG_C];
    f_v    = flags[FLG_V];
    sgn_ok = (f_n == f_v);
    unique case (cond)
      CC_EQ: pass = f_z;
      CC_NE: pass = !f_z;
      CC_HS: pass = f_c;
      CC_LO: pass = !f_c;
      CC_MI: pass = f_n;
      CC_PL: pass = !f_n;
      CC_VS: pass = f_v;
      CC_VC: pass = !f_v;
      CC_HI: pass = f_c && !f_z;
      CC_LS: pass = !f_c || f_z;
      CC_GE: pass = sgn_ok;
      CC_LT: pass = !sgn_ok;
      CC_GT: pass = !f_z && sgn_ok;
      CC_LE: pass = f_z || !sgn_ok;
      CC_AL: pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/br_target_calc.sv
module br_target_calc
  import br_pkg::*;
#(
  parameter int PC_AHEAD  = 8,
  parameter int LINK_STEP = 4
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFFS_W-1:0] offset,
  output logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] seq_pc
);
  localparam int SH     = 2;
  localparam int EXT_W  = ADDR_W - OFFS_W - SH;
  localparam logic [ADDR_W-1:0] AHEAD = ADDR_W'(PC_AHEAD);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(LINK_STEP);

  logic [ADDR_W-1:0] byte_off;

  generate
    if (EXT_W > 0) begin : g_ext
      assign byte_off = {{EXT_W{offset[OFFS_W-1]}}, offset, {SH{1'b0}}};
    end else begin : g_trunc
      assign byte_off = ADDR_W'({offset, {SH{1'b0}}});
    end
  endgenerate

  // sums wrap naturally at ADDR_W bits
  assign target = pc + AHEAD + byte_off;
  assign seq_pc = pc + STEP;
endmodule

// File: rtl/br_out_stage.sv
module br_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q;
  logic [W-1:0] data_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (in_valid && in_ready) begin
      vld_q  <= 1'b1;
      data_q <= in_data;
    end else if (out_ready) begin
      vld_q  <= 1'b0;
    end
  end

  // R8: a stalled result stays put
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R7: an accepted word produces a result next cycle
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
endmodule

// File: rtl/br_resolver.sv
module br_resolver
  import br_pkg::*;
#(
  parameter int PC_AHEAD  = 8,
  parameter int LINK_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] in_insn,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic [FLAG_W-1:0] in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_taken,
  output logic [ADDR_W-1:0] out_next_pc,
  output logic              out_link_we,
  output logic [ADDR_W-1:0] out_link_pc
);
  cond_e             cond;
  logic              is_branch, is_link, pass;
  logic [OFFS_W-1:0] offset;
  logic [ADDR_W-1:0] target, seq_pc;
  br_result_t        res_d, res_q;
  logic [RES_W-1:0]  res_bits;

  br_decode u_dec (
    .insn(in_insn), .cond(cond), .is_branch(is_branch),
    .is_link(is_link), .offset(offset)
  );

  br_cond_eval u_cond (
    .cond(cond), .flags(in_flags), .pass(pass)
  );

  br_target_calc #(.PC_AHEAD(PC_AHEAD), .LINK_STEP(LINK_STEP)) u_tgt (
    .pc(in_pc), .offset(offset), .target(target), .seq_pc(seq_pc)
  );

  always_comb begin
    res_d.taken   = is_branch && pass;
    res_d.next_pc = res_d.taken ? target : seq_pc;
    res_d.link_we = res_d.taken && is_link;
    res_d.link_pc = seq_pc;
  end

  br_out_stage #(.W(RES_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(res_d),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(res_bits)
  );

  assign res_q       = br_result_t'(res_bits);
  assign out_taken   = res_q.taken;
  assign out_next_pc = res_q.next_pc;
  assign out_link_we = res_q.link_we;
  assign out_link_pc = res_q.link_pc;

  // R2: the never code cannot yield a taken result
  a_r2_never: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_insn[INSN_W-1 -: COND_W] == CC_NV) |=> !out_taken);

  // R6: link write only accompanies a taken branch
  a_r6_link_taken: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_link_we |-> out_taken);

  // R5: a fall-through result continues at the return address
  a_r5_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_taken |-> out_next_pc == out_link_pc);

  // R3: a non-branch class word is never taken
  a_r3_non_branch: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_insn[27:25] != BR_CLASS) |=> !out_taken && !out_link_we);
endmodule

// File: tb/br_resolver_tb.sv
module br_resolver_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_insn = '0;
  logic [31:0] in_pc = '0;
  logic [3:0]  in_flags = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_taken;
  logic [31:0] out_next_pc;
  logic        out_link_we;
  logic [31:0] out_link_pc;

  always #2 clk = ~clk;  // 250 MHz

  br_resolver u_dut (.*);

  typedef struct {
    logic        taken;
    logic [31:0] nxt;
    logic        lwe;
    logic [31:0] lpc;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   bp_en = 0;
  int   cyc = 0;

  function automatic logic cpass(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'h0: return z;          4'h1: return !z;
      4'h2: return cy;         4'h3: return !cy;
      4'h4: return n;          4'h5: return !n;
      4'h6: return v;          4'h7: return !v;
      4'h8: return cy & !z;    4'h9: return !cy | z;
      4'hA: return n == v;     4'hB: return n != v;
      4'hC: return !z & (n == v);
      4'hD: return z | (n != v);
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] insn, input logic [31:0] pc,
                      input logic [3:0] fl, input string tag);
    exp_t e;
    logic br;
    br      = (insn[27:25] == 3'b101);
    e.taken = br && cpass(insn[31:28], fl);
    e.nxt   = e.taken ? pc + 32'd8 + {{6{insn[23]}}, insn[23:0], 2'b00} : pc + 32'd4;
    e.lwe   = e.taken && insn[24];
    e.lpc   = pc + 32'd4;
    e.tag   = tag;
    sb.push_back(e);
    in_insn  = insn;
    in_pc    = pc;
    in_flags = fl;
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // back-pressure generator
  always @(posedge clk) #1 out_ready <= bp_en ? (($urandom % 3) != 0) : 1'b1;

  // monitor / scoreboard
  initial begin
    logic [31:0] p_nxt, p_lpc;
    logic        p_tk, p_lwe;
    bit          held;
    exp_t        e;
    held = 0;
    p_nxt = '0; p_lpc = '0; p_tk = 0; p_lwe = 0;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (held)
          check(p_nxt == out_next_pc && p_lpc == out_link_pc &&
                p_tk == out_taken && p_lwe == out_link_we,
                "R8", "stalled result changed", out_next_pc, p_nxt);
        if (!out_ready)
          check(!in_ready, "R8", "in_ready while stalled", 32'(in_ready), 32'd0);
        if (out_ready) begin
          if (sb.size() == 0) begin
            check(0, "R8", "unexpected result", out_next_pc, 32'd0);
          end else begin
            e = sb.pop_front();
            check(out_taken == e.taken, e.tag, "taken", 32'(out_taken), 32'(e.taken));
            check(out_next_pc == e.nxt, e.tag, "next_pc", out_next_pc, e.nxt);
            check(out_link_we == e.lwe, e.tag, "link_we", 32'(out_link_we), 32'(e.lwe));
            check(out_link_pc == e.lpc, e.tag, "link_pc", out_link_pc, e.lpc);
          end
        end
        held  = !out_ready;
        p_nxt = out_next_pc; p_lpc = out_link_pc;
        p_tk  = out_taken;   p_lwe = out_link_we;
      end else begin
        held = 0;
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] oc;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9", "out_valid in reset", 32'(out_valid), 32'd0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R9", "idle after reset",
          {30'd0, out_valid, in_ready}, 32'd1);
    @(posedge clk); #1;

    // worked example, Z clear then set
    send(32'h1AFFFFF9, 32'h0000_1000, 4'b0000, "R4");
    @(negedge clk);
    check(out_valid == 1'b1, "R7", "result one cycle after accept", 32'(out_valid), 32'd1);
    @(posedge clk); #1;
    send(32'h1AFFFFF9, 32'h0000_1000, 4'b0100, "R5");
    // link variants
    send(32'hEB00_0010, 32'h0000_2000, 4'b0000, "R6");
    send(32'h0B00_0010, 32'h0000_2000, 4'b0000, "R6");
    send(32'hEA00_0010, 32'h0000_2000, 4'b0000, "R6");
    // wrap cases and offset extremes
    send(32'hEA00_0000, 32'hFFFF_FFF8, 4'b0000, "R10");
    send(32'hEAFF_FFFC, 32'h0000_0000, 4'b0000, "R10");
    send(32'hEA7F_FFFF, 32'h1000_0000, 4'b0000, "R4");
    send(32'hEA80_0000, 32'h1000_0000, 4'b0000, "R4");
    send(32'hEA00_0000, 32'hFFFF_FFFC, 4'b0100, "R10");
    // non-branch classes under an always condition
    for (int k = 0; k < 8; k++) begin
      oc = 4'(k);
      if (oc[2:0] != 3'b101)
        send({4'hE, oc[2:0], 1'b1, 24'(k * 32'h1357)}, $urandom, 4'hF, "R3");
    end
    // full condition/flag sweep under back-pressure
    bp_en = 1;
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        send({4'(c), 3'b101, 1'($urandom), 24'($urandom)}, $urandom, 4'(f),
             (c == 15) ? "R2" : "R1");
    bp_en = 0;
    while (sb.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule